// File: doc/BRIEF.md
# One-Shot Device-Clock Countdown Timer

This block is a one-shot down-counter controlled through one 32-bit word. Software writes the word: the top bit arms the timer and the low 27 bits give the delay, counted in cycles of the 60 MHz device clock the block runs on. When the count runs out, the block emits a single-cycle timeout pulse toward the interrupt logic, where it feeds source bit 16. On that same edge the stored word is cleared to zero.

A write with the arm bit set replaces any countdown already running. A write with the arm bit clear stores the word and cancels any pending timeout. Reading returns the last word written, or zero once the timer has expired. Bits 30:27 are stored and read back, but they do not change the delay.

Top module: `otg_tmr`

## Requirements
- R1: After reset, `rd_data_o` is 0 and `timeout_o` is low.
- R2: On the edge where `wr_en_i` is high, the whole 32-bit `wr_data_i` is stored, and it appears on `rd_data_o` right after that edge.
- R3: A write with bit 31 set and delay N (bits 26:0) raises `timeout_o` for the cycle that follows the (N+1)-th rising edge after the write edge.
- R4: A write with bit 31 set while a countdown is running discards the old countdown and restarts from the new delay.
- R5: A write with bit 31 clear cancels any pending timeout: no pulse follows, and the written word stays readable.
- R6: On the expiry edge, `rd_data_o` becomes 0 in the same cycle that `timeout_o` goes high.
- R7: `timeout_o` is high for exactly one cycle per expiry.
- R8: A delay of 0 with bit 31 set expires on the first edge after the write.
- R9: Bits 30:27 have no effect on the delay. They are stored and read back unchanged.
- R10: A write that lands on the expiry edge wins: no pulse is emitted, and the new word is stored and acted on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Device clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Written word: bit 31 arm, bits 26:0 delay |
| rd_data_o | output | 32 | Stored word, 0 after expiry |
| timeout_o | output | 1 | One-cycle expiry pulse |

## Verification
The assertions check on every cycle that:
- a written word is visible on the next cycle;
- an arming write loads the delay and an idle armed counter decrements by one;
- the pulse never lasts two cycles;
- the read value is zero whenever the pulse is high;
- a disarming write is never followed by a pulse.

Only the bench scenarios can show end-to-end behaviour:
- the exact delay from write to pulse for zero, small, large and high-bit-polluted delays;
- that a restart moves the pulse;
- that a write landing exactly on the expiry edge suppresses it.

// File: rtl/otg_tmr_pkg.sv
package otg_tmr_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned EN_POS = 31;
  localparam int unsigned CNT_W  = 27;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  typedef struct packed {
    logic arm;
    logic disarm;
    cnt_t delay;
  } cmd_t;
endpackage

// File: rtl/otg_tmr_cmd.sv
module otg_tmr_cmd #(
  parameter int unsigned WORD_W = otg_tmr_pkg::WORD_W,
  parameter int unsigned EN_POS = otg_tmr_pkg::EN_POS,
  parameter int unsigned CNT_W  = otg_tmr_pkg::CNT_W
) (
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic              arm_o,
  output logic              disarm_o,
  output logic [CNT_W-1:0]  delay_o
);
  assign arm_o    = wr_en_i &&  wr_data_i[EN_POS];
  assign disarm_o = wr_en_i && !wr_data_i[EN_POS];
  // bits between the count field and the enable are ignored here
  assign delay_o  = wr_data_i[CNT_W-1:0];
endmodule

// File: rtl/otg_tmr_count.sv
module otg_tmr_count #(
  parameter int unsigned CNT_W = otg_tmr_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             disarm_i,
  input  logic [CNT_W-1:0] delay_i,
  output logic             hit_o,
  output logic             pulse_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;

  // expiry this edge, unless a write overrides it
  assign hit_o = armed_q && (cnt_q == '0) && !arm_i && !disarm_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= hit_o;
      if (arm_i) begin
        cnt_q   <= delay_i;
        armed_q <= 1'b1;
      end else if (disarm_i || hit_o) begin
        armed_q <= 1'b0;
      end else if (armed_q) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  a_r3_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> (armed_q && cnt_q == $past(delay_i)));
  a_r3_decrement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && cnt_q != '0 && !arm_i && !disarm_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
  a_r5_cancel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disarm_i |=> !pulse_o);
endmodule

// File: rtl/otg_tmr_word.sv
module otg_tmr_word #(
  parameter int unsigned WORD_W = otg_tmr_pkg::WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              clr_i,
  output logic [WORD_W-1:0] word_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      word_o <= '0;
    else if (wr_en_i) word_o <= wr_data_i;
    else if (clr_i)   word_o <= '0;
  end

  a_r2_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (word_o == $past(wr_data_i)));
endmodule

// File: rtl/otg_tmr.sv
module otg_tmr #(
  parameter int unsigned WORD_W = otg_tmr_pkg::WORD_W,
  parameter int unsigned EN_POS = otg_tmr_pkg::EN_POS,
  parameter int unsigned CNT_W  = otg_tmr_pkg::CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              timeout_o
);
  logic             arm, disarm, hit;
  logic [CNT_W-1:0] delay;

  otg_tmr_cmd #(.WORD_W(WORD_W), .EN_POS(EN_POS), .CNT_W(CNT_W)) u_cmd (
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .arm_o    (arm),
    .disarm_o (disarm),
    .delay_o  (delay)
  );

  otg_tmr_count #(.CNT_W(CNT_W)) u_count (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_i   (arm),
    .disarm_i(disarm),
    .delay_i (delay),
    .hit_o   (hit),
    .pulse_o (timeout_o)
  );

  otg_tmr_word #(.WORD_W(WORD_W)) u_word (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .clr_i    (hit),
    .word_o   (rd_data_o)
  );

  a_r6_cleared_on_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (rd_data_o == '0));
  a_r10_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !timeout_o);
endmodule

// File: tb/otg_tmr_bench.sv
module otg_tmr_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        timeout;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int pulses = 0;
  bit done = 0;
  int exp_q[$];

  always #10 clk = ~clk;

  otg_tmr u_otg_tmr (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .timeout_o(timeout)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compare pulses against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (timeout) begin
        pulses++;
        if (exp_q.size() == 0) chk(0, "R5/R7 unexpected pulse", cyc, 0);
        else begin
          chk(cyc == exp_q[0], "R3 pulse cycle", cyc, exp_q[0]);
          void'(exp_q.pop_front());
        end
        chk(rd_data == 32'h0, "R6 cleared on expiry", rd_data, 0);
      end else if (exp_q.size() != 0 && cyc > exp_q[0]) begin
        chk(0, "R3 missed pulse", cyc, exp_q[0]);
        void'(exp_q.pop_front());
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: write on the next edge and predict the pulse
  task automatic wr(input logic [31:0] w);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = w;
    exp_q.delete();
    if (w[31]) exp_q.push_back(cyc + 1 + int'(w[26:0]) + 1);
    @(negedge clk);
    wr_en = 1'b0;
    chk(rd_data == w, "R2 readback", rd_data, w);
  endtask

  task automatic drain(input int n);
    idle(n);
    chk(exp_q.size() == 0, "R3 all pulses seen", exp_q.size(), 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int p0;
    idle(2);
    chk(rd_data == 0, "R1 reset read", rd_data, 0);
    chk(timeout == 0, "R1 reset pulse", timeout, 0);
    rst_n = 1'b1;
    idle(2);

    wr(32'h8000_0005); drain(12);                    // R3
    wr(32'h8000_0000); drain(5);                     // R8
    wr(32'h8000_0001); drain(5);                     // R7
    wr(32'hF800_0003); drain(8);                     // R9 high bits set
    wr(32'h7800_0003);                               // R9 stored, no arm
    p0 = pulses; idle(10);
    chk(pulses == p0, "R9 no arm", pulses, p0);
    chk(rd_data == 32'h7800_0003, "R9 stored", rd_data, 32'h7800_0003);

    wr(32'h8000_0014); idle(5);                      // R4 restart
    wr(32'h8000_0002); drain(30);

    wr(32'h8000_0008); idle(3);                      // R5 cancel
    wr(32'h0000_0008);
    p0 = pulses; idle(15);
    chk(pulses == p0, "R5 no pulse", pulses, p0);
    chk(rd_data == 32'h0000_0008, "R5 word kept", rd_data, 8);

    // R10: second write lands on the expiry edge (w+6)
    wr(32'h8000_0005); idle(4);
    p0 = pulses;
    wr(32'h0000_0123);
    idle(10);
    chk(pulses == p0, "R10 write wins", pulses, p0);
    chk(rd_data == 32'h0000_0123, "R10 word", rd_data, 32'h123);

    wr(32'h8000_0005); idle(4);                      // R10 re-arm on expiry edge
    wr(32'h8000_0002); drain(10);

    wr(32'h8000_03E8); drain(1010);                  // R3 long delay

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule